// File: doc/BRIEF.md
# PLL Power Sequencer

This block brings a phase-locked loop up or down in a fixed, ordered series of steps whenever one request level changes. A rising request clears the clock-gate control and applies PLL power, then releases isolation and finally enables the PLL. A falling request performs the reverse teardown. The teardown does not touch the clock-gate control. Each step except the last of the teardown is followed by a wait. The waits are not counted in core clock cycles. They are measured on a free-running reference-time counter that advances at 13 MHz, so they stay correct while the core clock itself is being changed.

The request is a level that names the wanted PLL state. A change made while a sequence runs is not acted on until that sequence is over. If the level then differs from the settled state, the opposite sequence starts. `busy` covers every running sequence. `done` pulses once when a sequence finishes. The lock wait at the end of power-up stands in for PLL lock time. No lock indicator is modelled.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset `pll_en`=0, `iso_en`=1, `pwr_on`=0, `clk_gate`=1, `busy`=0 and `done`=0.
- R2: While settled off with `pll_req`=1, the next clock edge sets `clk_gate`=0 and `pwr_on`=1 together and raises `busy`.
- R3: `iso_en` falls on the first edge at which `ref_cnt` has advanced at least 13 ticks (1 us) since the edge that applied power.
- R4: `pll_en` rises on the first edge at which `ref_cnt` has advanced at least 13 ticks since the edge that released isolation.
- R5: Power-up ends, with `done`, on the first edge at which `ref_cnt` has advanced at least 260 ticks (20 us) since the edge that raised `pll_en`.
- R6: While settled on with `pll_req`=0, the next edge clears `pll_en`. `iso_en` rises 13 ticks later, and `pwr_on` falls 13 ticks after that, ending the sequence. `clk_gate` never returns to 1 after reset.
- R7: Elapsed time is `ref_cnt` minus the start value modulo 2^CNT_W, so waits that span a counter wrap keep their length.
- R8: `busy` is 1 from the edge that starts a sequence to the edge that ends it, and 0 while settled.
- R9: `done` is a single-cycle pulse in the cycle after each sequence ends, coinciding with `busy`=0.
- R10: Request changes during a running sequence are deferred. At its end, a request that differs from the new settled state starts the opposite sequence on the next edge. A request that has returned to match starts nothing.
- R11: A request equal to the settled state causes no output change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_req | input | 1 | Wanted PLL state (1 = running) |
| ref_cnt | input | CNT_W | Free-running 13 MHz reference-time count, synchronous to `clk` |
| clk_gate | output | 1 | Clock-gate software control, 1 = gated |
| pwr_on | output | 1 | PLL power switch |
| iso_en | output | 1 | PLL output isolation |
| pll_en | output | 1 | PLL enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse of one sequence and the acceptance of a deferred opposite request meet at the same boundary. In the cycle where `done` is high, the sequencer samples the request to decide whether to start again. The bench provokes this by flipping `pll_req` partway through a teardown, and again partway through a power-up and back. A behavioural model compares every output on every clock. Directed checks then confirm two things: the new power-up begins exactly one cycle after the teardown's `done`, and a request that reverts mid-sequence produces no further activity. Wait lengths are judged at two reference-counter rates and across a counter wrap.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  typedef enum logic [2:0] {
    PS_OFF     = 3'd0,
    PS_UP_PWR  = 3'd1,
    PS_UP_ISO  = 3'd2,
    PS_UP_LOCK = 3'd3,
    PS_ON      = 3'd4,
    PS_DN_EN   = 3'd5,
    PS_DN_ISO  = 3'd6
  } pseq_state_e;

  // One strobe per sequencing step, valid for one cycle at the edge that performs it.
  typedef struct packed {
    logic pwr_up;   // clear clock gate, apply power
    logic iso_off;  // release isolation
    logic pll_on;   // enable PLL
    logic lock_end; // lock wait elapsed
    logic pll_off;  // disable PLL
    logic iso_on;   // assert isolation
    logic pwr_dn;   // remove power
  } pseq_step_t;

  function automatic int unsigned us_to_ticks(input int unsigned us, input int unsigned tpu);
    return us * tpu;
  endfunction

  function automatic logic is_settled(input pseq_state_e s);
    return (s == PS_OFF) || (s == PS_ON);
  endfunction

endpackage

// File: rtl/pllseq_wait.sv
module pllseq_wait #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SHORT_TICKS = 13,
  parameter int unsigned LONG_TICKS  = 260
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ref_cnt,
  input  logic             arm,
  input  logic             long_sel,
  output logic             wait_done
);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_TICKS);

  // Modulo-2^CNT_W difference: correct across counter wrap.
  function automatic logic [CNT_W-1:0] elapsed_ticks(input logic [CNT_W-1:0] now,
                                                     input logic [CNT_W-1:0] since);
    return now - since;
  endfunction

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (!rst_n)   start_q <= '0;
    else if (arm) start_q <= ref_cnt;
  end

  assign elapsed   = elapsed_ticks(ref_cnt, start_q);
  assign limit     = long_sel ? LONG_LIM : SHORT_LIM;
  assign wait_done = (elapsed >= limit);

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wait_done,
  output pseq_state_e state,
  output pseq_step_t  step,
  output logic        arm,
  output logic        long_sel,
  output logic        seq_end,
  output logic        busy
);
  pseq_state_e nxt;

  always_comb begin
    nxt  = state;
    step = '0;
    unique case (state)
      PS_OFF:     if (req)       begin nxt = PS_UP_PWR;  step.pwr_up   = 1'b1; end
      PS_UP_PWR:  if (wait_done) begin nxt = PS_UP_ISO;  step.iso_off  = 1'b1; end
      PS_UP_ISO:  if (wait_done) begin nxt = PS_UP_LOCK; step.pll_on   = 1'b1; end
      PS_UP_LOCK: if (wait_done) begin nxt = PS_ON;      step.lock_end = 1'b1; end
      PS_ON:      if (!req)      begin nxt = PS_DN_EN;   step.pll_off  = 1'b1; end
      PS_DN_EN:   if (wait_done) begin nxt = PS_DN_ISO;  step.iso_on   = 1'b1; end
      PS_DN_ISO:  if (wait_done) begin nxt = PS_OFF;     step.pwr_dn   = 1'b1; end
      default:    nxt = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_OFF;
    else        state <= nxt;
  end

  assign arm      = step.pwr_up | step.iso_off | step.pll_on | step.pll_off | step.iso_on;
  assign seq_end  = step.lock_end | step.pwr_dn;
  assign long_sel = (state == PS_UP_LOCK);
  assign busy     = !is_settled(state);

endmodule

// File: rtl/pllseq_drv.sv
module pllseq_drv
  import pllseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pseq_step_t step,
  input  logic       seq_end,
  output logic       clk_gate,
  output logic       pwr_on,
  output logic       iso_en,
  output logic       pll_en,
  output logic       done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_gate <= 1'b1;
      pwr_on   <= 1'b0;
      iso_en   <= 1'b1;
      pll_en   <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (step.pwr_up)  begin clk_gate <= 1'b0; pwr_on <= 1'b1; end
      if (step.iso_off) iso_en <= 1'b0;
      if (step.pll_on)  pll_en <= 1'b1;
      if (step.pll_off) pll_en <= 1'b0;
      if (step.iso_on)  iso_en <= 1'b1;
      if (step.pwr_dn)  pwr_on <= 1'b0;
      done <= seq_end;
    end
  end

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pllseq_pkg::*;
#(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned TICKS_PER_US = 13,
  parameter int unsigned STEP_US      = 1,
  parameter int unsigned LOCK_US      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_req,
  input  logic [CNT_W-1:0] ref_cnt,
  output logic             clk_gate,
  output logic             pwr_on,
  output logic             iso_en,
  output logic             pll_en,
  output logic             busy,
  output logic             done
);
  localparam int unsigned STEP_TICKS = us_to_ticks(STEP_US, TICKS_PER_US);
  localparam int unsigned LOCK_TICKS = us_to_ticks(LOCK_US, TICKS_PER_US);

  pseq_state_e state;
  pseq_step_t  step;
  logic        arm;
  logic        long_sel;
  logic        wait_done;
  logic        seq_end;

  pllseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (pll_req),
    .wait_done (wait_done),
    .state     (state),
    .step      (step),
    .arm       (arm),
    .long_sel  (long_sel),
    .seq_end   (seq_end),
    .busy      (busy)
  );

  pllseq_wait #(
    .CNT_W       (CNT_W),
    .SHORT_TICKS (STEP_TICKS),
    .LONG_TICKS  (LOCK_TICKS)
  ) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_cnt   (ref_cnt),
    .arm       (arm),
    .long_sel  (long_sel),
    .wait_done (wait_done)
  );

  pllseq_drv u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .seq_end  (seq_end),
    .clk_gate (clk_gate),
    .pwr_on   (pwr_on),
    .iso_en   (iso_en),
    .pll_en   (pll_en),
    .done     (done)
  );

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_gate,
  input logic pwr_on,
  input logic iso_en,
  input logic pll_en,
  input logic busy,
  input logic done,
  input logic wait_done
);
  AST_PLL_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> (pwr_on && !iso_en)); // R4
  AST_ISO_WHEN_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> iso_en); // R6
  AST_ISO_DROP_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> ($past(wait_done) && $past(pwr_on))); // R3
  AST_PLL_RISE_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> ($past(wait_done) && !$past(iso_en))); // R4
  AST_GATE_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(clk_gate)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_DONE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wait_done)); // R5
endmodule

bind pll_pwr_seq pll_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_gate  (clk_gate),
  .pwr_on    (pwr_on),
  .iso_en    (iso_en),
  .pll_en    (pll_en),
  .busy      (busy),
  .done      (done),
  .wait_done (wait_done)
);

// File: tb/tb_pll_pwr_seq.sv
module tb_pll_pwr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pll_req = 1'b0;
  logic [31:0] ref_cnt = 32'd0;
  logic [31:0] ref_step = 32'd1;
  logic clk_gate, pwr_on, iso_en, pll_en, busy, done;

  int n_chk = 0, n_fail = 0, cyc_n = 0;
  bit finished = 1'b0;

  pll_pwr_seq dut (
    .clk(clk), .rst_n(rst_n), .pll_req(pll_req), .ref_cnt(ref_cnt),
    .clk_gate(clk_gate), .pwr_on(pwr_on), .iso_en(iso_en), .pll_en(pll_en),
    .busy(busy), .done(done)
  );

  always #10 clk = ~clk; // 50 MHz

  // Behavioural reference model
  bit m_cg, m_pwr, m_iso, m_pll, m_busy, m_done, m_on, m_dir;
  int m_phase;
  logic [31:0] m_start, m_el;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cg = 1; m_pwr = 0; m_iso = 1; m_pll = 0; m_busy = 0; m_done = 0;
      m_on = 0; m_dir = 0; m_phase = 0; m_start = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (pll_req != m_on) begin
          m_dir = pll_req; m_phase = 1; m_start = ref_cnt;
          if (pll_req) begin m_cg = 0; m_pwr = 1; end
          else m_pll = 0;
        end
      end else begin
        m_el = ref_cnt - m_start;
        if (m_el >= ((m_dir && m_phase == 3) ? 32'd260 : 32'd13)) begin
          if (m_dir) begin
            if (m_phase == 1) m_iso = 0;
            if (m_phase == 2) m_pll = 1;
            if (m_phase == 3) begin m_phase = 0; m_on = 1; m_done = 1; end
            else begin m_phase++; m_start = ref_cnt; end
          end else begin
            if (m_phase == 1) begin m_iso = 1; m_phase = 2; m_start = ref_cnt; end
            else begin m_pwr = 0; m_phase = 0; m_on = 0; m_done = 1; end
          end
        end
      end
      m_busy = (m_phase != 0);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  // event timestamps
  int t_cg_f, t_pwr_r, t_pwr_f, t_iso_f, t_iso_r, t_pll_r, t_pll_f, t_done, n_done;
  bit p_cg, p_pwr, p_iso, p_pll;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_n++;
      if (rst_n) begin
        check("R6 clk_gate", clk_gate, m_cg);
        check("R2 pwr_on",   pwr_on,   m_pwr);
        check("R3 iso_en",   iso_en,   m_iso);
        check("R4 pll_en",   pll_en,   m_pll);
        check("R8 busy",     busy,     m_busy);
        check("R9 done",     done,     m_done);
        if (!clk_gate && p_cg) t_cg_f = cyc_n;
        if (pwr_on && !p_pwr)  t_pwr_r = cyc_n;
        if (!pwr_on && p_pwr)  t_pwr_f = cyc_n;
        if (!iso_en && p_iso)  t_iso_f = cyc_n;
        if (iso_en && !p_iso)  t_iso_r = cyc_n;
        if (pll_en && !p_pll)  t_pll_r = cyc_n;
        if (!pll_en && p_pll)  t_pll_f = cyc_n;
        if (done) begin t_done = cyc_n; n_done++; end
      end
      p_cg = clk_gate; p_pwr = pwr_on; p_iso = iso_en; p_pll = pll_en;
      ref_cnt = ref_cnt + ref_step;
    end
  endtask

  task automatic wait_done_pulse();
    int k = 0;
    do begin cyc(1); k++; end while (!done && k < 3000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pll_en", pll_en, 0);
    check("R1 iso_en", iso_en, 1);
    check("R1 pwr_on", pwr_on, 0);
    check("R1 clk_gate", clk_gate, 1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    p_cg = clk_gate; p_pwr = pwr_on; p_iso = iso_en; p_pll = pll_en;

    // Power-up, one tick per cycle
    ref_cnt = 32'd1000; ref_step = 1; pll_req = 1'b1;
    wait_done_pulse();
    check("R2 gate and power same cycle", t_cg_f, t_pwr_r);
    check("R3 iso release delay", t_iso_f - t_pwr_r, 13);
    check("R4 pll enable delay", t_pll_r - t_iso_f, 13);
    check("R5 lock delay", t_done - t_pll_r, 260);

    // R11: request equals settled state
    cyc(30);
    check("R11 pll_en held", pll_en, 1);
    check("R11 busy idle", busy, 0);
    check("R11 no extra done", n_done, 1);

    // Power-down, two ticks per cycle
    ref_step = 2; pll_req = 1'b0;
    wait_done_pulse();
    check("R6 iso assert delay", t_iso_r - t_pll_f, 7);
    check("R6 power removal delay", t_pwr_f - t_iso_r, 7);
    check("R6 gate stays open", clk_gate, 0);
    check("R6 done with power off", t_done, t_pwr_f);
    cyc(5);

    // R7: sequence across counter wrap
    ref_cnt = 32'hFFFF_FFF0; ref_step = 1; pll_req = 1'b1;
    wait_done_pulse();
    check("R7 iso delay across wrap", t_iso_f - t_pwr_r, 13);
    check("R7 pll delay across wrap", t_pll_r - t_iso_f, 13);
    check("R7 lock delay across wrap", t_done - t_pll_r, 260);
    cyc(3);

    // R10: opposite request during teardown is serviced afterwards
    pll_req = 1'b0;
    cyc(3);
    pll_req = 1'b1;
    wait_done_pulse();
    check("R10 teardown completed", pwr_on, 0);
    cyc(1);
    check("R10 restart one cycle after done", t_pwr_r - t_done, 1);
    check("R10 busy on restart", busy, 1);
    wait_done_pulse();
    check("R10 restarted to on", pll_en, 1);
    cyc(2);

    // R10: request reverting mid-sequence starts nothing
    pll_req = 1'b0;
    wait_done_pulse();
    pll_req = 1'b1;
    cyc(4);
    pll_req = 1'b0;
    cyc(2);
    pll_req = 1'b1;
    wait_done_pulse();
    n_done = 0;
    cyc(25);
    check("R10 no follow-up sequence", n_done, 0);
    check("R10 stays on", pll_en, 1);
    check("R10 idle", busy, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule